// File: doc/BRIEF.md
# Weight Memory Address Sequencer

This block turns a choice of recurrent layer, gate and weight kind into the base address of that matrix in a flat weight memory. The memory holds each layer in the same amount of space, sized for the largest layer, which has a hidden size of 64. Within a layer, each of the four gates reserves three matrix slots: input weights, recurrent weights and a bias vector. A separate dense output layer sits after the last recurrent layer. Along with the address, the block reports the row and column counts of the selected matrix.

A target can be chosen in two ways. A load request takes a 6-bit control word and decodes it. A step request takes the next entry from an internal walker. The walker visits the targets in the order the network evaluates them: input weights, then recurrent weights, for each gate of each layer, then the dense layer, and then it starts again. The outputs are registered. They change only on the clock edge that samples a request.

The walker has two states. WALK_LAYERS covers the 32 recurrent entries. Its transitions are: KIND_NEXT (W to U), GATE_NEXT (U of a gate to W of the next gate), LAYER_NEXT (U of the last gate to W of gate 0 of the next layer) and TO_DENSE (U of the last gate of the last layer). WALK_DENSE holds the dense entry. Its only transition, WRAP, returns to layer 0, gate 0, W. Reset puts the walker in WALK_LAYERS at layer 0, gate 0, W.

Top module: `wgt_addr_seq`

## Requirements
- R1: While the synchronous reset is high, and after it is released with no request, `valid_o` is 0 and `base_addr_o`, `rows_o` and `cols_o` are 0.
- R2: The control word layout is: bit 5 is the dense flag, bits 4:3 the layer, bits 2:1 the gate, and bit 0 the kind (0 = input weights, 1 = recurrent weights). On a load with bit 5 clear, the next clock edge registers the address `BASE_ADDR + layer*49152 + gate*12288 + kind*4096`. These three strides are 4*GATE_STRIDE, 3*MATRIX_STRIDE and 64*64. `BASE_ADDR` defaults to 0.
- R3: On a load with bit 5 set, bits 4:0 are ignored. The registered address is the dense base, `BASE_ADDR + 4*49152` (196608). The dimensions are 8 rows by 64 columns.
- R4: For any recurrent-layer selection, `rows_o` and `cols_o` are both 64.
- R5: A step request (with load low) outputs the walker's current entry and advances it. The entries are ordered layer 0..3, then gate 0..3, then W before U.
- R6: After the 32 recurrent entries, the next step outputs the dense entry. The step after that wraps to layer 0, gate 0, W.
- R7: A load does not move the walker. The next step continues from where the walker stood.
- R8: When load and step are both high, the load is used and the walker does not advance.
- R9: `valid_o` rises one cycle after the first request following reset and stays high after that.
- R10: In a cycle with no request, all outputs keep their values.
- R11: A recurrent-layer address is always on a 4096-word boundary and never points at a bias slot.
- R12: A reset in the middle of a walk clears `valid_o`. The next step after it outputs layer 0, gate 0, W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load request: decode `ctrl_i` |
| ctrl_i | input | 6 | Control word (dense flag, layer, gate, kind) |
| step_i | input | 1 | Step request: use the walker's entry and advance |
| base_addr_o | output | 20 | Registered matrix base address |
| rows_o | output | 7 | Row count of the selected matrix |
| cols_o | output | 7 | Column count of the selected matrix |
| valid_o | output | 1 | Outputs hold a decoded selection |

## Verification
The hardest case to reach is the wrap from the dense entry back to the start. It needs 33 consecutive steps, and any load mixed in must leave the walker where it was. The stimulus walks the full sequence twice. In the middle of the walk it inserts loads, including a load in the same cycle as a step. A scoreboard tracks its own walker position and so detects any slip. A reset placed partway through a later walk checks that the walker restarts at the first entry.

// File: rtl/wgt_addr_pkg.sv
package wgt_addr_pkg;
    localparam int LAYER_W = 2;
    localparam int GATE_W  = 2;
    localparam int CTRL_W  = 1 + LAYER_W + GATE_W + 1;

    typedef struct packed {
        logic              dense;
        logic [LAYER_W-1:0] layer;
        logic [GATE_W-1:0]  gate;
        logic              kind;
    } wsel_t;

    typedef enum logic [0:0] {
        WALK_LAYERS = 1'b0,
        WALK_DENSE  = 1'b1
    } walk_state_t;
endpackage

// File: rtl/wgt_ctrl_decode.sv
module wgt_ctrl_decode
    import wgt_addr_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_i,
    output wsel_t             sel_o
);
    always_comb begin
        sel_o = '0;
        sel_o.dense = ctrl_i[CTRL_W-1];
        if (!ctrl_i[CTRL_W-1]) begin
            sel_o.layer = ctrl_i[CTRL_W-2 -: LAYER_W];
            sel_o.gate  = ctrl_i[GATE_W : 1];
            sel_o.kind  = ctrl_i[0];
        end
    end
endmodule

// File: rtl/wgt_walk_fsm.sv
module wgt_walk_fsm
    import wgt_addr_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int NUM_GATES  = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv_i,
    output wsel_t cur_o
);
    localparam logic [LAYER_W-1:0] LAST_LAYER = LAYER_W'(NUM_LAYERS - 1);
    localparam logic [GATE_W-1:0]  LAST_GATE  = GATE_W'(NUM_GATES - 1);

    walk_state_t        state_q, state_d;
    logic [LAYER_W-1:0] layer_q, layer_d;
    logic [GATE_W-1:0]  gate_q, gate_d;
    logic               kind_q, kind_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_LAYERS;
            layer_q <= '0;
            gate_q  <= '0;
            kind_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            layer_q <= layer_d;
            gate_q  <= gate_d;
            kind_q  <= kind_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        layer_d = layer_q;
        gate_d  = gate_q;
        kind_d  = kind_q;
        cur_o   = '0;
        unique case (state_q)
            WALK_LAYERS: begin
                cur_o.layer = layer_q;
                cur_o.gate  = gate_q;
                cur_o.kind  = kind_q;
                if (adv_i) begin
                    if (!kind_q) begin
                        kind_d = 1'b1;                       // KIND_NEXT
                    end else if (gate_q != LAST_GATE) begin
                        kind_d = 1'b0;                       // GATE_NEXT
                        gate_d = gate_q + 1'b1;
                    end else if (layer_q != LAST_LAYER) begin
                        kind_d  = 1'b0;                      // LAYER_NEXT
                        gate_d  = '0;
                        layer_d = layer_q + 1'b1;
                    end else begin
                        state_d = WALK_DENSE;                // TO_DENSE
                    end
                end
            end
            WALK_DENSE: begin
                cur_o.dense = 1'b1;
                if (adv_i) begin
                    state_d = WALK_LAYERS;                   // WRAP
                    layer_d = '0;
                    gate_d  = '0;
                    kind_d  = 1'b0;
                end
            end
            default: state_d = WALK_LAYERS;
        endcase
    end
endmodule

// File: rtl/wgt_offset_calc.sv
module wgt_offset_calc
    import wgt_addr_pkg::*;
#(
    parameter int BASE_ADDR    = 0,
    parameter int MAX_HIDDEN   = 64,
    parameter int NUM_LAYERS   = 4,
    parameter int NUM_GATES    = 4,
    parameter int SLOTS_PER_GATE = 3,
    parameter int DENSE_ROWS   = 8,
    parameter int DENSE_COLS   = 64,
    parameter int ADDR_W       = 20,
    parameter int DIM_W        = 7
) (
    input  wsel_t             sel_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DIM_W-1:0]  rows_o,
    output logic [DIM_W-1:0]  cols_o
);
    localparam int MATRIX_STRIDE = MAX_HIDDEN * MAX_HIDDEN;
    localparam int GATE_STRIDE   = SLOTS_PER_GATE * MATRIX_STRIDE;
    localparam int LAYER_STRIDE  = NUM_GATES * GATE_STRIDE;
    localparam int DENSE_BASE    = BASE_ADDR + NUM_LAYERS * LAYER_STRIDE;

    logic [ADDR_W-1:0] layer_off, gate_off, kind_off;

    always_comb begin
        layer_off = ADDR_W'(sel_i.layer) * ADDR_W'(LAYER_STRIDE);
        gate_off  = ADDR_W'(sel_i.gate)  * ADDR_W'(GATE_STRIDE);
        kind_off  = sel_i.kind ? ADDR_W'(MATRIX_STRIDE) : '0;
        if (sel_i.dense) begin
            addr_o = ADDR_W'(DENSE_BASE);
            rows_o = DIM_W'(DENSE_ROWS);
            cols_o = DIM_W'(DENSE_COLS);
        end else begin
            addr_o = ADDR_W'(BASE_ADDR) + layer_off + gate_off + kind_off;
            rows_o = DIM_W'(MAX_HIDDEN);
            cols_o = DIM_W'(MAX_HIDDEN);
        end
    end
endmodule

// File: rtl/wgt_addr_seq.sv
module wgt_addr_seq
    import wgt_addr_pkg::*;
#(
    parameter int BASE_ADDR  = 0,
    parameter int MAX_HIDDEN = 64,
    parameter int NUM_LAYERS = 4,
    parameter int NUM_GATES  = 4,
    parameter int DENSE_ROWS = 8,
    parameter int DENSE_COLS = 64,
    parameter int ADDR_W     = 20,
    parameter int DIM_W      = $clog2(MAX_HIDDEN) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [5:0]        ctrl_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] base_addr_o,
    output logic [DIM_W-1:0]  rows_o,
    output logic [DIM_W-1:0]  cols_o,
    output logic              valid_o
);
    wsel_t             dec_sel, walk_sel, use_sel;
    logic [ADDR_W-1:0] calc_addr;
    logic [DIM_W-1:0]  calc_rows, calc_cols;
    logic              walk_adv;

    assign walk_adv = step_i && !load_i;
    assign use_sel  = load_i ? dec_sel : walk_sel;

    wgt_ctrl_decode u_dec (
        .ctrl_i (ctrl_i),
        .sel_o  (dec_sel)
    );

    wgt_walk_fsm #(
        .NUM_LAYERS (NUM_LAYERS),
        .NUM_GATES  (NUM_GATES)
    ) u_walk (
        .clk   (clk),
        .rst   (rst),
        .adv_i (walk_adv),
        .cur_o (walk_sel)
    );

    wgt_offset_calc #(
        .BASE_ADDR  (BASE_ADDR),
        .MAX_HIDDEN (MAX_HIDDEN),
        .NUM_LAYERS (NUM_LAYERS),
        .NUM_GATES  (NUM_GATES),
        .DENSE_ROWS (DENSE_ROWS),
        .DENSE_COLS (DENSE_COLS),
        .ADDR_W     (ADDR_W),
        .DIM_W      (DIM_W)
    ) u_off (
        .sel_i  (use_sel),
        .addr_o (calc_addr),
        .rows_o (calc_rows),
        .cols_o (calc_cols)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr_o <= '0;
            rows_o      <= '0;
            cols_o      <= '0;
            valid_o     <= 1'b0;
        end else if (load_i || step_i) begin
            base_addr_o <= calc_addr;
            rows_o      <= calc_rows;
            cols_o      <= calc_cols;
            valid_o     <= 1'b1;
        end
    end
endmodule

// File: rtl/wgt_addr_seq_chk.sv
module wgt_addr_seq_chk #(
    parameter int BASE_ADDR  = 0,
    parameter int MAX_HIDDEN = 64,
    parameter int NUM_LAYERS = 4,
    parameter int NUM_GATES  = 4,
    parameter int DENSE_ROWS = 8,
    parameter int DENSE_COLS = 64,
    parameter int ADDR_W     = 20,
    parameter int DIM_W      = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic [5:0]        ctrl_i,
    input logic              step_i,
    input logic [ADDR_W-1:0] base_addr_o,
    input logic [DIM_W-1:0]  rows_o,
    input logic [DIM_W-1:0]  cols_o,
    input logic              valid_o
);
    localparam int MS    = MAX_HIDDEN * MAX_HIDDEN;
    localparam int DBASE = BASE_ADDR + NUM_LAYERS * NUM_GATES * 3 * MS;

    logic [ADDR_W-1:0] rel;
    assign rel = base_addr_o - ADDR_W'(BASE_ADDR);

    AST_VALID_SETS: assert property (@(posedge clk) disable iff (rst)
        (load_i || step_i) |=> valid_o);                                    // R9
    AST_VALID_STAYS: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o);                                               // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(load_i || step_i) |=> ($stable(base_addr_o) && $stable(rows_o) && $stable(cols_o))); // R10
    AST_DENSE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load_i && ctrl_i[5]) |=> (base_addr_o == ADDR_W'(DBASE) && rows_o == DIM_W'(DENSE_ROWS) && cols_o == DIM_W'(DENSE_COLS))); // R3
    AST_LAYER_DIMS: assert property (@(posedge clk) disable iff (rst)
        (load_i && !ctrl_i[5]) |=> (rows_o == DIM_W'(MAX_HIDDEN) && cols_o == DIM_W'(MAX_HIDDEN))); // R4
    AST_SLOT_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (valid_o && base_addr_o != ADDR_W'(DBASE)) |-> ((rel % ADDR_W'(MS)) == 0 && ((rel / ADDR_W'(MS)) % 3) != 2)); // R11
endmodule

bind wgt_addr_seq wgt_addr_seq_chk #(
    .BASE_ADDR  (BASE_ADDR),
    .MAX_HIDDEN (MAX_HIDDEN),
    .NUM_LAYERS (NUM_LAYERS),
    .NUM_GATES  (NUM_GATES),
    .DENSE_ROWS (DENSE_ROWS),
    .DENSE_COLS (DENSE_COLS),
    .ADDR_W     (ADDR_W),
    .DIM_W      (DIM_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .ctrl_i      (ctrl_i),
    .step_i      (step_i),
    .base_addr_o (base_addr_o),
    .rows_o      (rows_o),
    .cols_o      (cols_o),
    .valid_o     (valid_o)
);

// File: tb/wgt_addr_seq_tb.sv
module wgt_addr_seq_tb;
    localparam int DENSE_ADDR = 196608;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [5:0]  ctrl_i = '0;
    logic        step_i = 1'b0;
    logic [19:0] base_addr_o;
    logic [6:0]  rows_o, cols_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;
    int pos = 0;            // bench walker position, 0..32 (32 = dense)
    bit done = 0;

    int    q_addr[$];
    int    q_rows[$];
    string q_tag[$];

    always #10 clk = ~clk;

    wgt_addr_seq u_dut (
        .clk (clk), .rst (rst), .load_i (load_i), .ctrl_i (ctrl_i),
        .step_i (step_i), .base_addr_o (base_addr_o), .rows_o (rows_o),
        .cols_o (cols_o), .valid_o (valid_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sel_addr(input int l, input int g, input int k);
        return l * 49152 + g * 12288 + k * 4096;
    endfunction

    function automatic int pos_addr(input int p);
        if (p == 32) return DENSE_ADDR;
        return sel_addr(p / 8, (p / 2) % 4, p % 2);
    endfunction

    task automatic push(input int a, input int r, input string tag);
        q_addr.push_back(a);
        q_rows.push_back(r);
        q_tag.push_back(tag);
    endtask

    task automatic do_step(input string tag);
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b1;
        push(pos_addr(pos), (pos == 32) ? 8 : 64, tag);
        pos = (pos + 1) % 33;
    endtask

    task automatic do_load(input logic [5:0] cw, input bit with_step, input string tag);
        @(negedge clk);
        load_i = 1'b1; step_i = with_step; ctrl_i = cw;
        if (cw[5]) push(DENSE_ADDR, 8, tag);
        else push(sel_addr(cw[4:3], cw[2:1], cw[0]), 64, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            load_i = 1'b0; step_i = 1'b0;
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            begin
                bit req;
                req = (load_i || step_i) && !rst;
                #2;
                if (req) begin
                    if (q_addr.size() == 0) begin
                        check(0, "R5 unexpected result", int'(base_addr_o), -1);
                    end else begin
                        int ea, er;
                        string t;
                        ea = q_addr.pop_front();
                        er = q_rows.pop_front();
                        t  = q_tag.pop_front();
                        check(int'(base_addr_o) == ea, {t, " addr"}, int'(base_addr_o), ea);
                        check(int'(rows_o) == er && int'(cols_o) == 64, {t, " dims"}, int'(rows_o), er);
                        check(valid_o, {t, " R9 valid"}, int'(valid_o), 1);
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [19:0] held;
        repeat (3) @(negedge clk);
        check(valid_o == 0 && base_addr_o == 0 && rows_o == 0, "R1 reset state", int'(base_addr_o), 0);
        @(negedge clk); rst = 1'b0;
        idle(2);
        check(valid_o == 0 && base_addr_o == 0, "R1 idle after reset", int'(valid_o), 0);

        // R2/R4 explicit loads
        do_load(6'b0_00_00_0, 0, "R2 L0G0W");
        do_load(6'b0_11_11_1, 0, "R2 L3G3U");
        do_load(6'b0_10_01_1, 0, "R2 L2G1U");
        do_load(6'b0_01_10_0, 0, "R4 L1G2W");
        // R3 dense with varied ignored bits
        do_load(6'b1_00_00_0, 0, "R3 dense 0");
        do_load(6'b1_11_01_1, 0, "R3 dense junk");
        idle(1);
        held = base_addr_o;
        idle(3);
        check(base_addr_o == held && rows_o == 8, "R10 hold", int'(base_addr_o), int'(held));

        // R5/R7/R8: walk with loads inserted
        for (int i = 0; i < 10; i++) do_step("R5 walk");
        do_load(6'b0_11_00_1, 0, "R7 load mid-walk");
        do_step("R7 walk resumes");
        do_load(6'b0_01_01_0, 1, "R8 load wins");
        do_step("R8 walker not advanced");
        for (int i = 0; i < 20; i++) do_step("R5 walk");
        do_step("R6 dense entry");
        do_step("R6 wrap");
        for (int i = 0; i < 33; i++) do_step("R6 second pass");
        idle(2);

        // R12: reset mid-walk
        for (int i = 0; i < 5; i++) do_step("R12 pre-reset");
        idle(1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; pos = 0;
        check(valid_o == 0 && base_addr_o == 0, "R12 valid cleared", int'(valid_o), 0);
        do_step("R12 restart L0G0W");
        do_step("R12 then L0G0U");
        idle(3);
        check(q_addr.size() == 0, "R5 scoreboard drained", q_addr.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule